// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block lives in an always-on power domain next to a downstream interrupt controller. It receives a vector of shared peripheral interrupt lines and forwards them unchanged to that controller. It also holds one bank of 32-bit enable words for each of two CPUs. For each CPU it raises a wakeup request whenever an enabled interrupt line is pending.

Software reaches the enable words, a mode register and two spare auxiliary boot words through a single-cycle register port. The port has a write enable, a byte address, 32-bit write data and combinational read data. Line n is governed by bit n mod 32 of enable word n>>5. CPU1's bank sits 0x400 bytes above CPU0's, and consecutive words are 4 bytes apart.

Bit 5 of the mode register picks the wakeup policy. At 1 each CPU wakes only from its own enables. At 0 a request from either CPU wakes both.

Top module: `wake_gen`

## Requirements
- R1: After reset every enable word, the mode register and both auxiliary words read 0, and both wakeup outputs are 0.
- R2: `irq_fwd` equals `irq_in` at all times, whatever the enables and mode.
- R3: Enable word i of CPU c is at byte address c*0x400 + 4*i, for i below NUM_WORDS. It reads back the value last written. Writing one CPU's word leaves the other CPU's words unchanged.
- R4: When an enabled line rises, the wakeup output changes on the third rising clock edge after the change: two synchroniser stages, then the output register. A change to the enables shows on the wakeup output one edge after the write edge.
- R5: A pending line whose enable bit is 0 in both banks never raises a wakeup.
- R6: With bit 5 of the mode register (address 0x800) set to 1, CPU c's wakeup depends only on CPU c's enable bits.
- R7: With bit 5 of the mode register at 0, both wakeup outputs are equal, and either CPU's enabled pending line raises both.
- R8: The auxiliary words at 0x804 and 0x808 are 32-bit read/write storage.
- R9: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses are enable indices at or above NUM_WORDS, addresses that are not word-aligned, 0x80C and above, and everything from 0xC00 upward.
- R10: Writing 0xFFFFFFFF to an enable word unmasks all 32 of its lines. Writing 0 masks all 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_WORDS*32 | Shared peripheral interrupt lines |
| irq_fwd | output | NUM_WORDS*32 | Unchanged copy of the lines for the downstream controller |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| wake_o | output | 2 | Registered wakeup request, bit c for CPU c |

## Verification
The bench builds two instances. The first uses the default of five words per CPU and carries all the wakeup, policy and mapping tests, including lines in the first, middle and last word. The second uses four words and shows that index 4 (0x010), a valid word in the default build, becomes an unmapped hole that reads 0. That checks the bank-size boundary is taken from the parameter rather than fixed.

// File: rtl/wkg_pkg.sv
package wkg_pkg;

    localparam int WORD_W         = 32;
    localparam int NUM_CPU        = 2;
    localparam int ADDR_W         = 12;
    localparam int IDX_W          = 8;
    localparam int MODE_INDEP_BIT = 5;

    localparam logic [ADDR_W-1:0] MODE_ADDR = 12'h800;
    localparam logic [ADDR_W-1:0] AUX0_ADDR = 12'h804;
    localparam logic [ADDR_W-1:0] AUX1_ADDR = 12'h808;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN,
        SEL_MODE,
        SEL_AUX0,
        SEL_AUX1
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic             cpu;
        logic [IDX_W-1:0] word;
    } dec_t;

    // Bit 11 clear: enable banks, bit 10 picks the CPU (0x400 stride),
    // bits 9:2 pick the word. Bit 11 set: mode and auxiliary words.
    function automatic dec_t decode(input logic [ADDR_W-1:0] a, input int nwords);
        dec_t d;
        d.sel  = SEL_NONE;
        d.cpu  = a[10];
        d.word = a[9:2];
        if (a[1:0] == 2'b00) begin
            if (!a[11]) begin
                if (int'(a[9:2]) < nwords) d.sel = SEL_EN;
            end else if (a == MODE_ADDR) begin
                d.sel = SEL_MODE;
            end else if (a == AUX0_ADDR) begin
                d.sel = SEL_AUX0;
            end else if (a == AUX1_ADDR) begin
                d.sel = SEL_AUX1;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/wkg_sync.sv
module wkg_sync #(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wkg_regs.sv
module wkg_regs
    import wkg_pkg::*;
#(
    parameter int NUM_WORDS = 5,
    localparam int NUM_LINES = NUM_WORDS * WORD_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [WORD_W-1:0]                 rdata,
    output logic [NUM_CPU-1:0][NUM_LINES-1:0] en_o,
    output logic                              indep_o
);
    dec_t              dec;
    logic [WORD_W-1:0] en_q [NUM_CPU][NUM_WORDS];
    logic [WORD_W-1:0] mode_q, aux0_q, aux1_q;

    assign dec = decode(addr, NUM_WORDS);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        localparam logic CPU_ID = 1'(c);
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam logic [IDX_W-1:0] WORD_ID = IDX_W'(w);
            always_ff @(posedge clk) begin
                if (rst)
                    en_q[c][w] <= '0;
                else if (we && dec.sel == SEL_EN && dec.cpu == CPU_ID && dec.word == WORD_ID)
                    en_q[c][w] <= wdata;
            end
            assign en_o[c][w*WORD_W +: WORD_W] = en_q[c][w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            aux0_q <= '0;
            aux1_q <= '0;
        end else if (we) begin
            case (dec.sel)
                SEL_MODE: mode_q <= wdata;
                SEL_AUX0: aux0_q <= wdata;
                SEL_AUX1: aux1_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.sel)
            SEL_EN: begin
                for (int c = 0; c < NUM_CPU; c++)
                    for (int w = 0; w < NUM_WORDS; w++)
                        if (dec.cpu == 1'(c) && dec.word == IDX_W'(w))
                            rdata = en_q[c][w];
            end
            SEL_MODE: rdata = mode_q;
            SEL_AUX0: rdata = aux0_q;
            SEL_AUX1: rdata = aux1_q;
            default:  rdata = '0;
        endcase
    end

    assign indep_o = mode_q[MODE_INDEP_BIT];
endmodule

// File: rtl/wkg_wake.sv
module wkg_wake
    import wkg_pkg::*;
#(
    parameter int NUM_LINES = 160
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LINES-1:0]              irq_s,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0] en,
    input  logic                              indep,
    output logic [NUM_CPU-1:0]                wake_o
);
    logic [NUM_CPU-1:0] req;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_req
        assign req[c] = |(irq_s & en[c]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            wake_o <= '0;
        else if (indep)
            wake_o <= req;
        else
            wake_o <= {NUM_CPU{|req}};
    end
endmodule

// File: rtl/wake_gen.sv
module wake_gen
    import wkg_pkg::*;
#(
    parameter int NUM_WORDS = 5,
    localparam int NUM_LINES = NUM_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_fwd,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic [NUM_CPU-1:0]   wake_o
);
    logic [NUM_LINES-1:0]              irq_s;
    logic [NUM_CPU-1:0][NUM_LINES-1:0] en_all;
    logic                              mode_indep;

    assign irq_fwd = irq_in;

    wkg_sync #(.W(NUM_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (irq_s)
    );

    wkg_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .en_o    (en_all),
        .indep_o (mode_indep)
    );

    wkg_wake #(.NUM_LINES(NUM_LINES)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .irq_s  (irq_s),
        .en     (en_all),
        .indep  (mode_indep),
        .wake_o (wake_o)
    );
endmodule

// File: rtl/wake_gen_chk.sv
module wake_gen_chk
    import wkg_pkg::*;
#(
    parameter int NUM_WORDS = 5,
    localparam int NUM_LINES = NUM_WORDS * WORD_W
) (
    input logic                              clk,
    input logic                              rst,
    input logic [NUM_LINES-1:0]              irq_in,
    input logic [NUM_LINES-1:0]              irq_fwd,
    input logic                              reg_we,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [WORD_W-1:0]                 reg_wdata,
    input logic [WORD_W-1:0]                 reg_rdata,
    input logic [NUM_CPU-1:0]                wake_o,
    input logic [NUM_CPU-1:0][NUM_LINES-1:0] en_all,
    input logic                              mode_indep
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (wake_o == '0 && !mode_indep));

    // R2
    fwd_pass_chk: assert property (@(posedge clk) disable iff (rst) irq_fwd == irq_in);

    // R3
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && !$past(rst) && reg_addr == $past(reg_addr)
         && decode($past(reg_addr), NUM_WORDS).sel != SEL_NONE)
        |-> reg_rdata == $past(reg_wdata));

    // R5
    no_enable_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en_all) == '0) |-> wake_o == '0);

    // R7
    joint_wake_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(mode_indep) |-> wake_o[0] == wake_o[1]);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        decode(reg_addr, NUM_WORDS).sel == SEL_NONE |-> reg_rdata == '0);
endmodule

bind wake_gen wake_gen_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .irq_fwd    (irq_fwd),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wake_o     (wake_o),
    .en_all     (en_all),
    .mode_indep (mode_indep)
);

// File: tb/sim_wake_gen.sv
module sim_wake_gen;
    localparam int CLK_P = 10;
    localparam int NL    = 160;
    localparam int NL1   = 128;
    localparam int NV    = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] irq;
    logic [NL-1:0] fwd;
    logic [NL1-1:0] fwd1;
    logic          we;
    logic [11:0]   addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata, rdata1;
    logic [1:0]    wake, wake1;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wake_gen u0 (
        .clk(clk), .rst(rst), .irq_in(irq), .irq_fwd(fwd),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .wake_o(wake)
    );

    wake_gen #(.NUM_WORDS(4)) u1 (
        .clk(clk), .rst(rst), .irq_in(irq[NL1-1:0]), .irq_fwd(fwd1),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata1), .wake_o(wake1)
    );

    // {write address, write data, read address, expected read, requirement}
    localparam logic [91:0] VEC [NV] = '{
        {12'h000, 32'hA5A5_0001, 12'h000, 32'hA5A5_0001, 4'd3},  // R3 CPU0 word 0
        {12'h410, 32'hFFFF_FFFF, 12'h410, 32'hFFFF_FFFF, 4'd10}, // R10 CPU1 word 4
        {12'h404, 32'h1234_0000, 12'h004, 32'h0000_0000, 4'd3},  // R3 banks separate
        {12'h014, 32'hDEAD_BEEF, 12'h014, 32'h0000_0000, 4'd9},  // R9 index 5 unmapped
        {12'h804, 32'h1234_5678, 12'h804, 32'h1234_5678, 4'd8},  // R8 aux word 0
        {12'h808, 32'hCAFE_0042, 12'h808, 32'hCAFE_0042, 4'd8},  // R8 aux word 1
        {12'h800, 32'h0000_0020, 12'h800, 32'h0000_0020, 4'd6},  // R6 mode storage
        {12'hC04, 32'hFFFF_FFFF, 12'h000, 32'hA5A5_0001, 4'd9},  // R9 write ignored
        {12'h806, 32'h0000_0001, 12'h804, 32'h1234_5678, 4'd9}   // R9 misaligned
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] d1);
        @(negedge clk);
        addr = a;
        #1;
        d  = rdata;
        d1 = rdata1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, got1;
        rst = 1'b1; irq = '0; we = 1'b0; addr = '0; wdata = '0;
        do_reset();

        // R1 reset state
        bus_rd(12'h000, got, got1); check("R1 en cpu0", got, 32'h0);
        bus_rd(12'h410, got, got1); check("R1 en cpu1", got, 32'h0);
        bus_rd(12'h800, got, got1); check("R1 mode", got, 32'h0);
        bus_rd(12'h804, got, got1); check("R1 aux0", got, 32'h0);
        bus_rd(12'h808, got, got1); check("R1 aux1", got, 32'h0);
        check("R1 wake", {30'h0, wake}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_wr(VEC[i][91:80], VEC[i][79:48]);
            bus_rd(VEC[i][47:36], got, got1);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), got, VEC[i][35:4]);
        end

        // R9 with four words, index 4 is a hole in the smaller build
        bus_wr(12'h010, 32'h5555_AAAA);
        bus_rd(12'h010, got, got1);
        check("R9 small build index 4", got1, 32'h0);
        check("R3 default build index 4", got, 32'h5555_AAAA);

        do_reset();

        // R5: pending line 37 with nothing enabled
        @(negedge clk); irq[37] = 1'b1;
        repeat (5) @(negedge clk);
        check("R5 disabled line", {30'h0, wake}, 32'h0);
        // R2 forwarding
        check("R2 fwd word1", fwd[63:32], irq[63:32]);

        // R7: joint policy, CPU0 enable raises both
        bus_wr(12'h004, 32'h0000_0020);
        @(negedge clk);
        check("R7 joint wake", {30'h0, wake}, 32'h3);

        // R4 latency with independent policy
        bus_wr(12'h800, 32'h0000_0020);
        irq[37] = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 idle", {30'h0, wake}, 32'h0);
        irq[37] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 two edges", {30'h0, wake}, 32'h0);
        @(negedge clk);
        // R6 only CPU0 wakes
        check("R6 cpu0 only", {30'h0, wake}, 32'h1);

        // R6 CPU1 from its own enable on line 159
        irq[37] = 1'b0;
        bus_wr(12'h410, 32'h8000_0000);
        irq[159] = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 cpu1 only", {30'h0, wake}, 32'h2);
        check("R2 fwd word4", fwd[159:128], irq[159:128]);
        irq[159] = 1'b0;

        // R10 all-ones / all-zeros on CPU0 word 2
        irq[81] = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 before unmask", {30'h0, wake}, 32'h0);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R10 unmask all", {30'h0, wake}, 32'h1);
        bus_wr(12'h008, 32'h0000_0000);
        @(negedge clk);
        check("R10 mask all", {30'h0, wake}, 32'h0);
        irq[81] = 1'b0;

        // R7 back to joint: CPU1 line wakes both
        bus_wr(12'h800, 32'h0000_0000);
        irq[159] = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 cpu1 wakes both", {30'h0, wake}, 32'h3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule